// File: doc/BRIEF.md
# Multi-mode synchronous serial interface

An 8-bit synchronous serial port behind a small host register bus. One shift engine moves a byte at a time, most significant bit first. A transmit buffer feeds the engine and a receive buffer catches each finished byte. A write to the data register while the port is idle starts a transfer at once. A write made during a transfer waits in the transmit buffer and goes out directly after the current byte.

Three pin arrangements share the engine:
- **Two-wire:** one bidirectional data line plus a shift clock.
- **Three-wire:** separate serial in and serial out lines, with a common shift clock.
- **Chip-link:** the two-wire signalling moved onto a dedicated pad pair. The normal clock and data pins are then released (their enables stay low).

The shift clock comes from one of three internal tick strobes, from the system clock, or from an external clock pin. With an internal source the block is the clock master. With the external source the block follows the pin through a synchronizer. A completed byte can raise an interrupt pulse.

Top module: `sser_top`

## Requirements
- R1: After reset the status register (address 2) reads 0x01 and `irq_o`, `sd_oe_o`, `link_sc_oe_o` and `link_sd_oe_o` are low. `sc_o` is high. Status bits: bit0 = transmit buffer empty, bit1 = receive buffer full, bit2 = busy, bit3 = overrun.
- R2: Bits move most significant bit first. The output changes only on a falling shift clock edge and the input is sampled on a rising edge. A master makes exactly 8 clock cycles per byte (low then high) and idles the clock high.
- R3: Writing the data register (address 1) while idle starts a transfer. A write while busy is held: status bit0 reads 0 until that byte is loaded, and the byte is sent after the current one.
- R4: Each completed byte sets receive-full. Reading address 1 returns the last received byte and clears receive-full.
- R5: A byte completing while receive-full is set sets the overrun bit. Writing status with bit3 = 1 clears it.
- R6: Three-wire mode (control bit0 = 1, bit1 = 0) sends on `so_o`, receives from `si_i`, and keeps `sd_oe_o` low.
- R7: Two-wire mode (control bits 1:0 = 00) uses the `sd` line. `sd_oe_o` is high only while busy with control bit2 (transmit direction) = 1. In the receive direction the byte is taken from `sd_i`, and in the transmit direction `sd_i` still supplies the received byte.
- R8: Chip-link mode (control bit1 = 1, overriding bit0) uses the `link_*` pads and holds `sc_oe_o` and `sd_oe_o` low.
- R9: Control bits 5:3 select the clock source: 0 to 2 select `tick_i[n]`, 3 selects the system clock, and 4 to 7 select the external clock pin. A master toggles the clock once per selected tick. With the external source neither clock enable is driven.
- R10: With control bit6 = 1, `irq_o` pulses for one cycle, one clock after each completed byte.
- R11: Status bit2 is set from the start of a transfer until the last queued byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (data read clears receive-full) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| tick_i | input | 3 | Internal clock source strobes |
| sc_i | input | 1 | Shift clock pin, input side |
| sc_o | output | 1 | Shift clock pin, output side |
| sc_oe_o | output | 1 | Shift clock pin output enable |
| sd_i | input | 1 | Bidirectional data pin, input side |
| sd_o | output | 1 | Bidirectional data pin, output side |
| sd_oe_o | output | 1 | Bidirectional data pin output enable |
| si_i | input | 1 | Three-wire serial input |
| so_o | output | 1 | Three-wire serial output |
| link_sc_i | input | 1 | Chip-link clock pad, input side |
| link_sc_o | output | 1 | Chip-link clock pad, output side |
| link_sc_oe_o | output | 1 | Chip-link clock pad output enable |
| link_sd_i | input | 1 | Chip-link data pad, input side |
| link_sd_o | output | 1 | Chip-link data pad, output side |
| link_sd_oe_o | output | 1 | Chip-link data pad output enable |
| irq_o | output | 1 | Transfer-complete interrupt pulse |

## Verification
A wrong bit counter or a wrong shift order shows on the serial pins within the same byte: the clock cycle count per byte changes, or the scoreboard finds a wrong bit pattern at the eighth rising edge. A wrong buffer or flag state shows on the next status or data read, typically a few cycles after the byte ends. Queued-byte mistakes appear as a missing or repeated byte on the pins. A wrong pin enable shows as a driven line in a mode that must leave it released, and a sampler sees this during the same transfer.

// File: rtl/sser_pkg.sv
package sser_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_OVR  = 3;

  localparam int SEL_W = 3;

  typedef struct packed {
    logic             irq_en;
    logic [SEL_W-1:0] clk_sel;
    logic             dir_tx;
    logic             link_en;
    logic             wire3;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sser_clkgen.sv
module sser_clkgen #(
  parameter int N_TICK      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       active_i,
  input  logic [sser_pkg::SEL_W-1:0] sel_i,
  input  logic [N_TICK-1:0]          tick_i,
  input  logic                       ext_sc_i,
  output logic                       master_o,
  output logic                       sc_o,
  output logic                       rise_o,
  output logic                       fall_o
);
  localparam int SW = sser_pkg::SEL_W;

  logic [N_TICK:0]      src_vec;
  logic                 tick;
  logic                 sc_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise, ext_fall;

  assign src_vec  = {1'b1, tick_i};
  assign master_o = (sel_i <= SW'(N_TICK));

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i <= N_TICK; i++)
      if (sel_i == SW'(i)) tick = src_vec[i];
  end

  // external clock: synchronize, then one more stage for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_sc_i};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sc_q <= 1'b1;
    else if (!master_o)                   sc_q <= 1'b1;
    else if (active_i && tick)            sc_q <= ~sc_q;
  end

  assign sc_o   = sc_q;
  assign rise_o = active_i & (master_o ? (tick & ~sc_q) : ext_rise);
  assign fall_o = active_i & (master_o ? (tick &  sc_q) : ext_fall);
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         din_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_data_o,
  output logic         dout_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, dout_q;
  logic          last;

  assign last      = (cnt_q == CW'(W-1));
  assign done_o    = busy_q & rise_i & last;
  assign rx_data_o = {shreg_q[W-2:0], din_i};
  assign busy_o    = busy_q;
  assign dout_o    = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      dout_q  <= 1'b1;
    end else if (load_i) begin
      // output bit follows on the first falling edge, never at load
      shreg_q <= load_data_i;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (rise_i) begin
        shreg_q <= {shreg_q[W-2:0], din_i};
        cnt_q   <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
      if (fall_i) dout_q <= shreg_q[W-1];
    end
  end
endmodule

// File: rtl/sser_regs.sv
module sser_regs
  import sser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output ctrl_t             ctrl_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [W-1:0]      rx_data_i,
  output logic              load_o,
  output logic [W-1:0]      load_data_o,
  output logic              tx_full_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              irq_o
);
  ctrl_t               ctrl_q;
  logic [CTRL_W-1:0]   ctrl_bits;
  logic [W-1:0]        tx_buf_q, rx_buf_q, status;
  logic                tx_full_q, rx_full_q, ovr_q, irq_q;
  logic                wr_data, rd_data, wr_ctrl, wr_stat;

  assign wr_data = bus_wr_i && bus_addr_i == A_DATA;
  assign wr_ctrl = bus_wr_i && bus_addr_i == A_CTRL;
  assign wr_stat = bus_wr_i && bus_addr_i == A_STAT;
  assign rd_data = bus_rd_i && bus_addr_i == A_DATA;

  assign load_o      = (wr_data && !busy_i) || (done_i && (tx_full_q || wr_data));
  assign load_data_o = (done_i && tx_full_q) ? tx_buf_q : bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);

      // hold a write made mid-transfer unless it goes straight into the engine
      if (wr_data && busy_i && !(done_i && !tx_full_q)) begin
        tx_buf_q  <= bus_wdata_i;
        tx_full_q <= 1'b1;
      end else if (done_i && tx_full_q) begin
        tx_full_q <= 1'b0;
      end

      if (wr_stat && bus_wdata_i[ST_OVR]) ovr_q <= 1'b0;
      if (done_i) begin
        rx_buf_q  <= rx_data_i;
        rx_full_q <= 1'b1;
        if (rx_full_q) ovr_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end

      irq_q <= done_i & ctrl_q.irq_en;
    end
  end

  assign ctrl_bits = ctrl_q;

  always_comb begin
    status          = '0;
    status[ST_TXE]  = ~tx_full_q;
    status[ST_RXF]  = rx_full_q;
    status[ST_BUSY] = busy_i;
    status[ST_OVR]  = ovr_q;
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = W'(ctrl_bits);
      A_DATA:  bus_rdata_o = rx_buf_q;
      A_STAT:  bus_rdata_o = status;
      default: bus_rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign tx_full_o = tx_full_q;
  assign rx_full_o = rx_full_q;
  assign ovr_o     = ovr_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/sser_top.sv
module sser_top
  import sser_pkg::*;
#(
  parameter int W           = 8,
  parameter int N_TICK      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [N_TICK-1:0] tick_i,
  input  logic              sc_i,
  output logic              sc_o,
  output logic              sc_oe_o,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              si_i,
  output logic              so_o,
  input  logic              link_sc_i,
  output logic              link_sc_o,
  output logic              link_sc_oe_o,
  input  logic              link_sd_i,
  output logic              link_sd_o,
  output logic              link_sd_oe_o,
  output logic              irq_o
);
  ctrl_t        ctrl;
  logic         busy, done, load, master, sc_gen, rise, fall, din, dout;
  logic         tx_full, rx_full, ovr, drive_tx, ext_sc;
  logic [W-1:0] load_data, rx_data;

  sser_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_wdata_i, .bus_rdata_o,
    .ctrl_o(ctrl), .busy_i(busy), .done_i(done), .rx_data_i(rx_data),
    .load_o(load), .load_data_o(load_data),
    .tx_full_o(tx_full), .rx_full_o(rx_full), .ovr_o(ovr), .irq_o(irq_o)
  );

  sser_clkgen #(.N_TICK(N_TICK), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk_i, .rst_ni, .active_i(busy), .sel_i(ctrl.clk_sel), .tick_i,
    .ext_sc_i(ext_sc), .master_o(master), .sc_o(sc_gen), .rise_o(rise), .fall_o(fall)
  );

  sser_shifter #(.W(W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .load_data_i(load_data), .rise_i(rise),
    .fall_i(fall), .din_i(din), .busy_o(busy), .done_o(done),
    .rx_data_o(rx_data), .dout_o(dout)
  );

  // pin routing: chip-link overrides the three-wire select
  assign din      = ctrl.link_en ? link_sd_i : (ctrl.wire3 ? si_i : sd_i);
  assign ext_sc   = ctrl.link_en ? link_sc_i : sc_i;
  assign drive_tx = busy & ctrl.dir_tx;

  assign sc_o         = sc_gen;
  assign sc_oe_o      = master & ~ctrl.link_en;
  assign link_sc_o    = sc_gen;
  assign link_sc_oe_o = master & ctrl.link_en;

  assign sd_o         = dout;
  assign sd_oe_o      = drive_tx & ~ctrl.link_en & ~ctrl.wire3;
  assign link_sd_o    = dout;
  assign link_sd_oe_o = drive_tx & ctrl.link_en;
  assign so_o         = (ctrl.wire3 & ~ctrl.link_en) ? dout : 1'b1;
endmodule

// File: rtl/sser_checker.sv
module sser_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_o,
  input logic sc_o,
  input logic sc_oe_o,
  input logic sd_oe_o,
  input logic link_sc_oe_o,
  input logic link_sd_oe_o,
  input logic busy,
  input logic done,
  input logic master,
  input logic tx_full,
  input logic rx_full,
  input logic ovr,
  input logic link_en,
  input logic wire3,
  input logic dir_tx
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && master) |-> sc_o);  // R2
  AST_HELD_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full |-> busy);  // R3
  AST_RXF_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full);  // R4
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full) |=> ovr);  // R5
  AST_SD_OE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> (busy && dir_tx && !wire3));  // R7
  AST_LINK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_en |-> (!sc_oe_o && !sd_oe_o));  // R8
  AST_LINK_OE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_sd_oe_o |-> (busy && link_en));  // R8
  AST_EXT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master |-> (!sc_oe_o && !link_sc_oe_o));  // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);  // R10
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(done));  // R10
endmodule

bind sser_top sser_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .sc_o(sc_o), .sc_oe_o(sc_oe_o),
  .sd_oe_o(sd_oe_o), .link_sc_oe_o(link_sc_oe_o), .link_sd_oe_o(link_sd_oe_o),
  .busy(busy), .done(done), .master(master), .tx_full(tx_full), .rx_full(rx_full),
  .ovr(ovr), .link_en(ctrl.link_en), .wire3(ctrl.wire3), .dir_tx(ctrl.dir_tx)
);

// File: tb/test_sser_top.sv
module test_sser_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] tick = '0;
  logic       sc_ext = 1'b1, sd_bench = 1'b1;
  logic       sc_o, sc_oe_o, sd_o, sd_oe_o, so_o, si_i, sd_i;
  logic       link_sc_o, link_sc_oe_o, link_sd_o, link_sd_oe_o, link_sd_i, irq;

  always #10 clk = ~clk;  // 50 MHz

  assign si_i      = so_o;
  assign sd_i      = sd_oe_o ? sd_o : sd_bench;
  assign link_sd_i = link_sd_oe_o ? link_sd_o : 1'b1;

  sser_top i_sser_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .sc_i(sc_ext), .sc_o(sc_o), .sc_oe_o(sc_oe_o),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .si_i(si_i), .so_o(so_o),
    .link_sc_i(1'b1), .link_sc_o(link_sc_o), .link_sc_oe_o(link_sc_oe_o),
    .link_sd_i(link_sd_i), .link_sd_o(link_sd_o), .link_sd_oe_o(link_sd_oe_o),
    .irq_o(irq)
  );

  int n_chk = 0, n_err = 0, irq_cnt = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  int         mon_mode = 0;  // 0 so/sc, 1 sd/sc, 2 link, 3 so/ext clock
  bit         mon_en = 1;
  logic       mon_sc, mon_sd, mon_prev = 1'b1;
  logic [7:0] mon_sh;
  int         mon_bits = 0;

  always_comb begin
    case (mon_mode)
      1:       begin mon_sc = sc_o;      mon_sd = sd_o;      end
      2:       begin mon_sc = link_sc_o; mon_sd = link_sd_o; end
      3:       begin mon_sc = sc_ext;    mon_sd = so_o;      end
      default: begin mon_sc = sc_o;      mon_sd = so_o;      end
    endcase
  end

  // monitor: collect a bit at every rising shift clock, compare each byte
  always @(negedge clk) begin
    if (rst_n && mon_en && !mon_prev && mon_sc) begin
      mon_sh = {mon_sh[6:0], mon_sd};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) chk("R2 unexpected byte on pins", 32'(mon_sh), 32'hFFFF);
        else chk("R2 serial byte MSB first", 32'(mon_sh), 32'(exp_q.pop_front()));
      end
    end
    mon_prev = mon_sc;
    if (irq) irq_cnt++;
  end

  // external receive pattern for two-wire receive direction
  bit         rx_drive = 0;
  logic [7:0] rx_pat;
  int         rx_k = 0;
  logic       rxd_prev = 1'b1;
  bit         oe_seen = 0;
  always @(negedge clk) begin
    if (rx_drive) begin
      if (sd_oe_o) oe_seen = 1;
      if (rxd_prev && !sc_o && rx_k < 8) begin
        sd_bench = rx_pat[7-rx_k];
        rx_k++;
      end
    end
    rxd_prev = sc_o;
  end

  // internal tick source 1: one pulse every 4 cycles
  bit tick_run = 0;
  initial forever begin
    @(posedge clk); #1;
    tick[1] = 1'b0;
    if (tick_run) begin
      repeat (3) @(posedge clk);
      #1 tick[1] = 1'b1;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit expect_pins);
    if (expect_pins) exp_q.push_back(d);
    bus_wr(2'd1, d);
  endtask

  task automatic wait_idle(output int cycles);
    logic [7:0] s;
    cycles = 0;
    do begin
      bus_rd(2'd2, s);
      cycles += 2;
    end while (s[2] && cycles < 20000);
  endtask

  task automatic ext_clock();
    for (int i = 0; i < 8; i++) begin
      repeat (6) @(posedge clk); #1 sc_ext = 1'b0;
      repeat (6) @(posedge clk); #1 sc_ext = 1'b1;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd2, d);
    chk("R1 status after reset", 32'(d), 32'h01);
    chk("R1 sc idle high", 32'(sc_o), 32'h1);
    chk("R1 data and link enables low", 32'({sd_oe_o, link_sc_oe_o, link_sd_oe_o, irq}), 32'h0);

    // R6 three-wire, system clock (sel 3), irq enabled: 0x40|0x18|0x01
    bus_wr(2'd0, 8'h59);
    mon_mode = 0;
    send(8'hA5, 1);
    bus_rd(2'd2, d);
    chk("R11 busy during transfer", 32'(d), 32'h05);
    chk("R6 sd_oe low in three-wire", 32'(sd_oe_o), 32'h0);
    wait_idle(cyc);
    bus_rd(2'd2, d);
    chk("R4 receive full after byte", 32'(d), 32'h03);
    bus_rd(2'd1, d);
    chk("R6 loopback byte on si", 32'(d), 32'hA5);
    bus_rd(2'd2, d);
    chk("R4 read clears receive full", 32'(d), 32'h01);
    chk("R10 one irq per byte", 32'(irq_cnt), 32'd1);

    // R3 queued write, R5 overrun
    send(8'h3C, 1);
    send(8'hC3, 1);
    bus_rd(2'd2, d);
    chk("R3 held byte clears tx empty", 32'(d), 32'h04);
    wait_idle(cyc);
    bus_rd(2'd2, d);
    chk("R5 overrun after unread byte", 32'(d), 32'h0B);
    bus_rd(2'd1, d);
    chk("R3 second byte received last", 32'(d), 32'hC3);
    bus_wr(2'd2, 8'h08);
    bus_rd(2'd2, d);
    chk("R5 overrun cleared", 32'(d), 32'h01);
    chk("R2 no partial byte on pins", 32'(mon_bits), 32'd0);

    // R7 two-wire transmit: 0x40|0x18|0x04
    bus_wr(2'd0, 8'h5C);
    mon_mode = 1;
    send(8'h96, 1);
    chk("R7 sd_oe high while sending", 32'(sd_oe_o), 32'h1);
    wait_idle(cyc);
    chk("R7 sd_oe low after send", 32'(sd_oe_o), 32'h0);
    bus_rd(2'd1, d);
    chk("R7 line readback", 32'(d), 32'h96);

    // R7 two-wire receive: 0x40|0x18
    bus_wr(2'd0, 8'h58);
    mon_en = 0; rx_pat = 8'h5E; rx_k = 0; oe_seen = 0; rx_drive = 1;
    send(8'h00, 0);
    wait_idle(cyc);
    rx_drive = 0; sd_bench = 1'b1;
    chk("R7 sd not driven in receive", 32'(oe_seen), 32'h0);
    bus_rd(2'd1, d);
    chk("R7 byte from sd_i", 32'(d), 32'h5E);
    mon_en = 1;

    // R8 chip-link transmit: 0x40|0x18|0x04|0x02
    bus_wr(2'd0, 8'h5E);
    mon_mode = 2;
    send(8'h71, 1);
    chk("R8 normal pins released", 32'({sc_oe_o, sd_oe_o}), 32'h0);
    chk("R8 link pads driven", 32'({link_sc_oe_o, link_sd_oe_o}), 32'h3);
    wait_idle(cyc);
    bus_rd(2'd1, d);
    chk("R8 link loopback byte", 32'(d), 32'h71);

    // R9 internal tick 1: 0x40|0x08|0x01
    bus_wr(2'd0, 8'h49);
    mon_mode = 0;
    tick_run = 1;
    send(8'hE8, 1);
    wait_idle(cyc);
    tick_run = 0;
    chk("R9 tick source paces clock", 32'(cyc >= 60), 32'h1);
    bus_rd(2'd1, d);
    chk("R9 byte via tick source", 32'(d), 32'hE8);

    // R9 external clock: 0x40|0x20|0x01
    bus_wr(2'd0, 8'h61);
    mon_mode = 3;
    chk("R9 no clock drive in external mode", 32'({sc_oe_o, link_sc_oe_o}), 32'h0);
    send(8'h1D, 1);
    ext_clock();
    wait_idle(cyc);
    bus_rd(2'd1, d);
    chk("R9 byte via external clock", 32'(d), 32'h1D);

    repeat (4) @(negedge clk);
    chk("R2 all bytes seen on pins", 32'(exp_q.size()), 32'd0);
    chk("R10 irq count", 32'(irq_cnt), 32'd8);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule